// File: doc/BRIEF.md
# Clocked Hysteresis Heater Controller

This block switches a heater on and off around a setpoint with a fixed dead band of two units on each side. On every rising clock edge it compares a signed temperature reading with a signed setpoint. A reading at or below the lower threshold turns the heater on. A reading at or above the upper threshold turns it off. A reading strictly inside the band leaves the heater as it was.

The heater state lives in a single edge-triggered register, so it is never transparent. A glitch on the comparator outputs between clock edges cannot change it.

Both thresholds are formed one bit wider than the inputs. Setpoints at either end of the signed range therefore never wrap around. When both threshold conditions are true in the same cycle, switching on has priority.

Top module: `hyst_heater_ctrl`

## Requirements
- R1: Reset is synchronous and active high. An edge with reset asserted leaves the heater output at 0, even when the inputs meet the switch-on condition in that cycle.
- R2: At a rising edge where the measured value is less than or equal to setpoint minus 2, the heater output becomes 1.
- R3: At a rising edge where the measured value is greater than or equal to setpoint plus 2, and the switch-on condition is false, the heater output becomes 0.
- R4: While the measured value stays strictly between setpoint minus 2 and setpoint plus 2, the heater output holds its value for any number of cycles.
- R5: The output changes only at a rising clock edge, one cycle after the inputs are applied. Input changes between edges have no effect on the output.
- R6: The thresholds do not overflow. With a setpoint at the largest or smallest representable value, the comparison uses the true arithmetic value of setpoint plus or minus 2.
- R7: Setpoint and measured value are two's-complement signed numbers of W bits. Negative temperatures compare correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears the heater |
| setpoint | input | W | Signed target temperature |
| measured | input | W | Signed measured temperature |
| heater_on | output | 1 | Heater enable, registered |

## Verification
Reset and the switch-on decision can arrive in the same cycle. The bench provokes this by holding reset high while driving a reading far below the setpoint. It expects the output to stay at 0, and then to turn on at the first edge after reset is released. The switch-on and switch-off conditions can never both be true, because the band is nonempty. Their ordering is therefore judged by sweeping every setpoint and reading pair of a 4-bit configuration from both starting states, including the range ends where a narrow threshold would wrap.

// File: rtl/hyst_heater_pkg.sv
package hyst_heater_pkg;

    // Half-width of the dead band, in temperature units.
    localparam int unsigned BAND_HALF = 2;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } heat_cmd_t;

    typedef struct packed {
        logic low_hit;   // reading at or below lower threshold
        logic high_hit;  // reading at or above upper threshold
    } band_flags_t;

    // Switch-on wins over switch-off when both flags are raised.
    function automatic heat_cmd_t pick_cmd(input band_flags_t f);
        if (f.low_hit)
            return CMD_ON;
        else if (f.high_hit)
            return CMD_OFF;
        else
            return CMD_HOLD;
    endfunction

    function automatic logic next_heat(input heat_cmd_t c, input logic cur);
        case (c)
            CMD_ON:  return 1'b1;
            CMD_OFF: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/band_limits.sv
module band_limits
    import hyst_heater_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic signed [W-1:0] setpoint,
    output logic signed [W:0]   lo_lim,
    output logic signed [W:0]   hi_lim
);
    localparam int unsigned WX = W + 1;

    logic signed [WX-1:0] sp_wide;
    logic signed [WX-1:0] half;

    always_comb begin
        sp_wide = {setpoint[W-1], setpoint};
        half    = WX'(BAND_HALF);
        lo_lim  = sp_wide - half;
        hi_lim  = sp_wide + half;
    end

endmodule

// File: rtl/band_compare.sv
module band_compare
    import hyst_heater_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic signed [W-1:0] measured,
    input  logic signed [W:0]   lo_lim,
    input  logic signed [W:0]   hi_lim,
    output band_flags_t         flags
);
    logic signed [W:0] meas_wide;

    always_comb begin
        meas_wide      = {measured[W-1], measured};
        flags.low_hit  = (meas_wide <= lo_lim);
        flags.high_hit = (meas_wide >= hi_lim);
    end

endmodule

// File: rtl/heat_state.sv
module heat_state
    import hyst_heater_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  band_flags_t flags,
    output logic        heat_q
);
    heat_cmd_t cmd;

    always_comb cmd = pick_cmd(flags);

    always_ff @(posedge clk) begin
        if (rst)
            heat_q <= 1'b0;
        else
            heat_q <= next_heat(cmd, heat_q);
    end

    // R4: with no flag raised the register keeps its value
    a_r4_hold_in_band: assert property (@(posedge clk) disable iff (rst)
        (!flags.low_hit && !flags.high_hit) |=> $stable(heat_q));

endmodule

// File: rtl/hyst_heater_ctrl.sv
module hyst_heater_ctrl
    import hyst_heater_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] setpoint,
    input  logic signed [W-1:0] measured,
    output logic                heater_on
);
    logic signed [W:0] lo_lim;
    logic signed [W:0] hi_lim;
    band_flags_t       flags;

    band_limits #(.W(W)) limits_i (
        .setpoint (setpoint),
        .lo_lim   (lo_lim),
        .hi_lim   (hi_lim)
    );

    band_compare #(.W(W)) compare_i (
        .measured (measured),
        .lo_lim   (lo_lim),
        .hi_lim   (hi_lim),
        .flags    (flags)
    );

    heat_state state_i (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .heat_q (heater_on)
    );

    // Port-level reference thresholds, formed independently of the limit unit
    logic signed [W+1:0] ref_meas;
    logic signed [W+1:0] ref_sp;

    always_comb begin
        ref_meas = {{2{measured[W-1]}}, measured};
        ref_sp   = {{2{setpoint[W-1]}}, setpoint};
    end

    // R1: an edge with reset asserted leaves the heater off
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !heater_on);

    // R2, R6, R7: switch-on condition seen one edge later
    a_r2_turn_on: assert property (@(posedge clk) disable iff (rst)
        (ref_meas + 2 <= ref_sp) |=> heater_on);

    // R3, R6, R7: switch-off condition seen one edge later
    a_r3_turn_off: assert property (@(posedge clk) disable iff (rst)
        (ref_meas >= ref_sp + 2) |=> !heater_on);

    // R4: strictly inside the band the output does not move
    a_r4_no_toggle: assert property (@(posedge clk) disable iff (rst)
        ((ref_meas + 2 > ref_sp) && (ref_meas < ref_sp + 2)) |=> $stable(heater_on));

endmodule

// File: tb/hyst_heater_ctrl_tb_top.sv
module hyst_heater_ctrl_tb_top;

    localparam int  W      = 4;
    localparam time PERIOD = 10ns;
    localparam int  VMIN   = -(1 << (W - 1));
    localparam int  VMAX   = (1 << (W - 1)) - 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [W-1:0] setpoint = '0;
    logic signed [W-1:0] measured = '0;
    logic                heater_on;

    int n_checks = 0;
    int n_errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    hyst_heater_ctrl #(.W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .setpoint  (setpoint),
        .measured  (measured),
        .heater_on (heater_on)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (heater_on !== exp) begin
            n_errors++;
            $display("FAIL %s: sp=%0d meas=%0d heater_on=%0b expected=%0b",
                     req, setpoint, measured, heater_on, exp);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge (one rising edge between).
    task automatic apply(input int sp, input int m, input logic r);
        @(negedge clk);
        setpoint = W'(sp);
        measured = W'(m);
        rst      = r;
        @(negedge clk);
    endtask

    function automatic logic model(input int sp, input int m, input logic prev);
        if (m <= sp - 2)      return 1'b1;
        else if (m >= sp + 2) return 1'b0;
        else                  return prev;
    endfunction

    initial begin
        #(PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset held together with a switch-on condition
        apply(0, VMIN, 1'b1);
        apply(0, VMIN, 1'b1);
        check("R1 reset beats switch-on", 1'b0);
        apply(0, VMIN, 1'b0);
        check("R2 on after reset release", 1'b1);
        apply(0, 0, 1'b1);
        check("R1 reset clears an on heater", 1'b0);
        apply(0, 0, 1'b0);
        check("R4 hold off after reset", 1'b0);

        // R5: mid-cycle input pulse and one-edge latency
        @(negedge clk);
        setpoint = W'(0);
        measured = W'(VMIN);
        #1;
        check("R5 no change before edge", 1'b0);
        #1;
        measured = W'(0);
        @(negedge clk);
        check("R5 glitch between edges ignored", 1'b0);
        measured = W'(-2);
        #1;
        check("R5 still old value before edge", 1'b0);
        @(negedge clk);
        check("R5 output after one edge", 1'b1);

        // R6: range-end setpoints, thresholds must not wrap
        apply(VMAX, VMAX, 1'b0);
        check("R6 top of range in band holds on", 1'b1);
        apply(VMIN, VMIN, 1'b0);
        check("R6 bottom of range in band holds on", 1'b1);
        apply(0, VMAX, 1'b0);
        apply(VMIN, VMIN, 1'b0);
        check("R6 bottom of range in band holds off", 1'b0);
        apply(VMAX, VMAX - 2, 1'b0);
        check("R6 top of range lower edge switches on", 1'b1);

        // Exhaustive sweep from both starting states (R2, R3, R4, R7)
        for (int start = 0; start < 2; start++) begin
            for (int sp = VMIN; sp <= VMAX; sp++) begin
                for (int m = VMIN; m <= VMAX; m++) begin
                    logic exp;
                    if (start == 0) apply(0, VMAX, 1'b0);
                    else            apply(0, VMIN, 1'b0);
                    exp = model(sp, m, logic'(start));
                    apply(sp, m, 1'b0);
                    if (m <= sp - 2)
                        check("R2 switch-on sweep", exp);
                    else if (m >= sp + 2)
                        check("R3 switch-off sweep", exp);
                    else
                        check("R7 signed in-band sweep", exp);
                    if (m > sp - 2 && m < sp + 2) begin
                        for (int k = 0; k < 3; k++) begin
                            @(negedge clk);
                            check("R4 no toggle in band", exp);
                        end
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule